// File: doc/BRIEF.md
# GPIO Pad Data Port

This block holds the data side of a bank of general-purpose pads. Every pad owns a one-bit output data register that software can read and write, and a one-bit input data register that is read-only and shows the level sampled from the pad. Reading the input register tells software what is actually on the pin, which may differ from the value it last stored. Each pad's output path is set by three configuration inputs. These choose between the GPIO path and an alternate function, between push-pull and open-drain drive, and whether the GPIO driver is enabled at all.

The register window is byte addressed. Bit 3 of the address selects the output data bank (0) or the input data bank (1). Bits 2:0 give the pad offset, so byte offset k belongs to pad k. A single request of 8, 16 or 32 bits covers one, two or four consecutive pads in one transaction. Pad offset k sits in byte lane k mod 4 of the data bus (lane l is bits 8l+7:8l), and the pad value is bit 0 of its lane. Each request gets exactly one response on the following cycle. Requests may arrive on back-to-back cycles. A small response state machine has three states: RSP_IDLE, RSP_DATA and RSP_FAULT. From any state it moves to RSP_FAULT when the request in that cycle is illegal, to RSP_DATA when the request is legal, and to RSP_IDLE when no request is present. NUM_PADS must be a power of two, at least 8.

Top module: `gpio_port`

## Requirements
- R1: After reset every output data register reads 0 and rsp_valid is low. With all configuration inputs at 0, every pad_oe and pad_out is 0.
- R2: A request accepted on one clock edge gives rsp_valid high for exactly the next cycle. A cycle without a request gives no response on the next cycle.
- R3: req_size encodes 0 as 8 bits, 1 as 16 bits and 2 as 32 bits. The request covers one, two or four pads starting at the addressed offset. The pad value is returned in, and taken from, bit 0 of byte lane (offset mod 4).
- R4: On a write, only pads whose covered lane has its req_be bit set are updated. req_be is ignored on reads. Bits 7:1 of every lane read as 0 and are not stored.
- R5: A request is answered with rsp_err=1 and rsp_rdata=0, and changes no register, in any of these cases: a 16-bit request with address bit 0 set, a 32-bit request with address bits 1:0 not zero, or req_size=3.
- R6: Reads of the input bank (address bit 3 = 1) return the pad_in level through a two-flop synchronizer. A pad change is seen by a read captured three or more edges later, and is not seen by a read captured on the second edge after the change. Writes to the input bank are answered without error and change nothing.
- R7: A pad in GPIO mode with cfg_out_en=1 and cfg_od=0 has pad_oe=1 and pad_out equal to its output data register.
- R8: A pad in GPIO mode with cfg_out_en=1 and cfg_od=1 has pad_out=0. Its pad_oe is 1 when the stored value is 0 and 0 when the stored value is 1.
- R9: With cfg_alt=1 the pad follows alt_out and alt_oe, and its input register still shows the pad. Writes to its output register are stored and read back. The stored value reaches the pad once cfg_alt returns to 0.
- R10: A pad in GPIO mode with cfg_out_en=0 has pad_oe=0 and pad_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 4 | Byte address: bit 3 bank, bits 2:0 pad offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_be | input | 4 | Byte-lane write enables |
| req_wdata | input | 32 | Write data, one pad per lane in bit 0 |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Read data |
| cfg_alt | input | 8 | Per pad: 1 alternate function, 0 GPIO |
| cfg_od | input | 8 | Per pad: 1 open-drain, 0 push-pull |
| cfg_out_en | input | 8 | Per pad: GPIO driver enable |
| alt_out | input | 8 | Alternate-function output level |
| alt_oe | input | 8 | Alternate-function output enable |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Pad output level |
| pad_oe | output | 8 | Pad output enable |

## Verification
The response assertions assume that req_size and req_addr are valid whenever req_valid is high. They also assume a request is held for exactly one cycle, so each response follows a single request. The bench drives requests only at the falling edge and releases them after one cycle. Configuration and alternate-function inputs change only between requests. The pad assertions hold for any configuration pattern, so random configurations stay within them. pad_in changes only while the bus is idle. After a change the bench waits at least three cycles before it expects to see the new level, except in the one directed read that looks at the synchronizer latency on purpose.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_DATA  = 2'd1,
        RSP_FAULT = 2'd2
    } rsp_state_e;

    localparam int LANES  = 4;
    localparam int DATA_W = 8 * LANES;
endpackage

// File: rtl/gpio_port_decode.sv
`timescale 1ns/1ps
module gpio_port_decode
    import gpio_port_pkg::*;
#(
    parameter  int NUM_PADS = 8,
    localparam int PAD_AW   = $clog2(NUM_PADS),
    localparam int ADDR_W   = PAD_AW + 1,
    localparam int WORD_W   = PAD_AW - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    output logic [LANES-1:0]  lane_mask,
    output logic [WORD_W-1:0] word_idx,
    output logic              to_input,
    output logic              fault
);
    logic [1:0] lane;

    assign lane     = addr[1:0];
    assign word_idx = addr[PAD_AW-1:2];
    assign to_input = addr[PAD_AW];

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                lane_mask = 4'b0001 << lane;
                fault     = 1'b0;
            end
            SZ_HALF: begin
                lane_mask = lane[0] ? 4'b0000 : (4'b0011 << {lane[1], 1'b0});
                fault     = lane[0];
            end
            SZ_WORD: begin
                lane_mask = (lane == 2'd0) ? 4'b1111 : 4'b0000;
                fault     = (lane != 2'd0);
            end
            default: begin
                lane_mask = 4'b0000;
                fault     = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/gpio_port_sync.sv
`timescale 1ns/1ps
module gpio_port_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_port_drive.sv
`timescale 1ns/1ps
module gpio_port_drive #(
    parameter int NUM_PADS = 8
) (
    input  logic [NUM_PADS-1:0] dout,
    input  logic [NUM_PADS-1:0] cfg_alt,
    input  logic [NUM_PADS-1:0] cfg_od,
    input  logic [NUM_PADS-1:0] cfg_out_en,
    input  logic [NUM_PADS-1:0] alt_out,
    input  logic [NUM_PADS-1:0] alt_oe,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe
);
    for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
        always_comb begin
            if (cfg_alt[g]) begin
                pad_oe[g]  = alt_oe[g];
                pad_out[g] = alt_out[g];
            end else if (!cfg_out_en[g]) begin
                pad_oe[g]  = 1'b0;
                pad_out[g] = 1'b0;
            end else if (cfg_od[g]) begin
                pad_oe[g]  = ~dout[g];
                pad_out[g] = 1'b0;
            end else begin
                pad_oe[g]  = 1'b1;
                pad_out[g] = dout[g];
            end
        end
    end
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter  int NUM_PADS = 8,
    localparam int PAD_AW   = $clog2(NUM_PADS),
    localparam int ADDR_W   = PAD_AW + 1,
    localparam int WORD_W   = PAD_AW - 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic [LANES-1:0]    req_be,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [DATA_W-1:0]   rsp_rdata,
    input  logic [NUM_PADS-1:0] cfg_alt,
    input  logic [NUM_PADS-1:0] cfg_od,
    input  logic [NUM_PADS-1:0] cfg_out_en,
    input  logic [NUM_PADS-1:0] alt_out,
    input  logic [NUM_PADS-1:0] alt_oe,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe
);
    logic [LANES-1:0]    lane_mask;
    logic [WORD_W-1:0]   word_idx;
    logic                to_input;
    logic                fault;
    logic [NUM_PADS-1:0] in_sync;
    logic [NUM_PADS-1:0] dout_q;
    logic [NUM_PADS-1:0] wr_hit;
    logic                wr_go;
    logic [DATA_W-1:0]   rd_word;
    logic [DATA_W-1:0]   rdata_q;
    logic                unused_wdata;
    rsp_state_e          state_q;
    rsp_state_e          state_d;

    gpio_port_decode #(.NUM_PADS(NUM_PADS)) u_decode (
        .addr      (req_addr),
        .size      (acc_size_e'(req_size)),
        .lane_mask (lane_mask),
        .word_idx  (word_idx),
        .to_input  (to_input),
        .fault     (fault)
    );

    gpio_port_sync #(.WIDTH(NUM_PADS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (in_sync)
    );

    gpio_port_drive #(.NUM_PADS(NUM_PADS)) u_drive (
        .dout       (dout_q),
        .cfg_alt    (cfg_alt),
        .cfg_od     (cfg_od),
        .cfg_out_en (cfg_out_en),
        .alt_out    (alt_out),
        .alt_oe     (alt_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    // Only bit 0 of each lane carries pad data.
    assign unused_wdata = ^(req_wdata & 32'hFEFE_FEFE);

    assign wr_go = req_valid && req_write && !fault && !to_input;

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_out_reg
        localparam int LANE = p % LANES;
        localparam int WORD = p / LANES;

        assign wr_hit[p] = wr_go && (word_idx == WORD_W'(WORD))
                           && lane_mask[LANE] && req_be[LANE];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dout_q[p] <= 1'b0;
            end else if (wr_hit[p]) begin
                dout_q[p] <= req_wdata[8*LANE];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane_mask[l]) begin
                rd_word[8*l] = to_input ? in_sync[{word_idx, 2'(l)}]
                                        : dout_q[{word_idx, 2'(l)}];
            end
        end
    end

    always_comb begin
        if (!req_valid) begin
            state_d = RSP_IDLE;
        end else if (fault) begin
            state_d = RSP_FAULT;
        end else begin
            state_d = RSP_DATA;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (req_valid && !req_write && !fault) ? rd_word : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE: begin
                rsp_valid = 1'b0;
                rsp_err   = 1'b0;
                rsp_rdata = '0;
            end
            RSP_DATA: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b0;
                rsp_rdata = rdata_q;
            end
            RSP_FAULT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
                rsp_rdata = '0;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_err   = 1'b0;
                rsp_rdata = '0;
            end
        endcase
    end
endmodule

// File: rtl/gpio_port_checker.sv
`timescale 1ns/1ps
module gpio_port_checker #(
    parameter int NUM_PADS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [1:0]          req_lane,
    input logic [1:0]          req_size,
    input logic                rsp_valid,
    input logic                rsp_err,
    input logic [31:0]         rsp_rdata,
    input logic [NUM_PADS-1:0] cfg_alt,
    input logic [NUM_PADS-1:0] cfg_od,
    input logic [NUM_PADS-1:0] cfg_out_en,
    input logic [NUM_PADS-1:0] alt_out,
    input logic [NUM_PADS-1:0] alt_oe,
    input logic [NUM_PADS-1:0] pad_out,
    input logic [NUM_PADS-1:0] pad_oe
);
    logic illegal_req;
    assign illegal_req = (req_size == 2'd3)
                      || (req_size == 2'd1 && req_lane[0])
                      || (req_size == 2'd2 && req_lane != 2'd0);

    assert_rsp_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_illegal_faults_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && illegal_req) |=> rsp_err);

    assert_fault_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'h0));

    assert_upper_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_rdata & 32'hFEFE_FEFE) == 32'h0));

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad_chk
        assert_alt_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_alt[i] |-> (pad_oe[i] == alt_oe[i] && pad_out[i] == alt_out[i]));

        assert_od_never_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_alt[i] && cfg_od[i]) |-> !pad_out[i]);

        assert_driver_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_alt[i] && !cfg_out_en[i]) |-> !pad_oe[i]);

        assert_pp_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_alt[i] && cfg_out_en[i] && !cfg_od[i]) |-> pad_oe[i]);
    end
endmodule

bind gpio_port gpio_port_checker #(.NUM_PADS(NUM_PADS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_lane   (req_addr[1:0]),
    .req_size   (req_size),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .cfg_alt    (cfg_alt),
    .cfg_od     (cfg_od),
    .cfg_out_en (cfg_out_en),
    .alt_out    (alt_out),
    .alt_oe     (alt_oe),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [3:0]    req_addr = '0;
    logic [1:0]    req_size = '0;
    logic [3:0]    req_be = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [31:0]   rsp_rdata;
    logic [NP-1:0] cfg_alt = '0;
    logic [NP-1:0] cfg_od = '0;
    logic [NP-1:0] cfg_out_en = '0;
    logic [NP-1:0] alt_out = '0;
    logic [NP-1:0] alt_oe = '0;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    int n_cmp = 0;
    int n_bad = 0;
    logic [NP-1:0] mdl = '0;
    logic [NP-1:0] pin_exp = '0;

    gpio_port #(.NUM_PADS(NP)) uut (.*);

    always #2.5 clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_pads(string tag);
        logic [NP-1:0] e_oe;
        logic [NP-1:0] e_out;
        for (int p = 0; p < NP; p++) begin
            if (cfg_alt[p]) begin
                e_oe[p] = alt_oe[p];  e_out[p] = alt_out[p];
            end else if (!cfg_out_en[p]) begin
                e_oe[p] = 1'b0;       e_out[p] = 1'b0;
            end else if (cfg_od[p]) begin
                e_oe[p] = ~mdl[p];    e_out[p] = 1'b0;
            end else begin
                e_oe[p] = 1'b1;       e_out[p] = mdl[p];
            end
        end
        #1;
        check(tag, {16'h0, pad_oe, pad_out}, {16'h0, e_oe, e_out});
    endtask

    task automatic access(bit w, logic [3:0] a, logic [1:0] sz, logic [3:0] be,
                          logic [31:0] wd, string tag);
        bit          ferr;
        logic [3:0]  mask;
        logic [31:0] erd;
        int          base;
        ferr = (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'd0);
        if (ferr)            mask = 4'b0000;
        else if (sz == 2'd0) mask = 4'b0001 << a[1:0];
        else if (sz == 2'd1) mask = 4'b0011 << a[1:0];
        else                 mask = 4'b1111;
        base = a[2] ? 4 : 0;
        erd = '0;
        if (!w) begin
            for (int l = 0; l < 4; l++) begin
                if (mask[l]) erd[8*l] = a[3] ? pin_exp[base+l] : mdl[base+l];
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a;
        req_size = sz; req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 rsp_valid", {31'h0, rsp_valid}, 32'h1);
        check({tag, " rsp_err"}, {31'h0, rsp_err}, {31'h0, ferr});
        check({tag, " rdata"}, rsp_rdata, erd);
        if (w && !ferr && !a[3]) begin
            for (int l = 0; l < 4; l++) begin
                if (mask[l] && be[l]) mdl[base+l] = wd[8*l];
            end
        end
    endtask

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rsp_valid idle", {31'h0, rsp_valid}, 32'h0);
        check_pads("R1 pads after reset");
        access(0, 4'd0, 2'd2, 4'h0, 32'h0, "R1 out word0");
        access(0, 4'd4, 2'd2, 4'h0, 32'h0, "R1 out word1");
        @(negedge clk);
        check("R2 no request no response", {31'h0, rsp_valid}, 32'h0);

        // R3: widths and lanes
        access(1, 4'd0, 2'd2, 4'hF, 32'hFFFF_FFFF, "R3 word write");
        access(0, 4'd0, 2'd2, 4'h0, 32'h0, "R3 word read");
        access(1, 4'd6, 2'd1, 4'hF, 32'h0101_0000, "R3 half write");
        access(0, 4'd7, 2'd0, 4'h0, 32'h0, "R3 byte read lane3");
        access(0, 4'd4, 2'd1, 4'h0, 32'h0, "R3 half read low");

        // R4: byte enables
        access(1, 4'd4, 2'd2, 4'b0101, 32'hFFFF_FFFF, "R4 be partial");
        access(0, 4'd4, 2'd2, 4'h0, 32'h0, "R4 be readback");

        // R5: illegal requests
        access(1, 4'd1, 2'd1, 4'hF, 32'h0, "R5 half misaligned");
        access(1, 4'd2, 2'd2, 4'hF, 32'h0, "R5 word misaligned");
        access(0, 4'd0, 2'd3, 4'hF, 32'h0, "R5 reserved size");
        access(0, 4'd0, 2'd2, 4'h0, 32'h0, "R5 unchanged");

        // R6: input bank, synchronizer latency, ignored writes
        pad_in = 8'hA5;
        repeat (3) @(negedge clk);
        pin_exp = pad_in;
        access(0, 4'd8, 2'd2, 4'h0, 32'h0, "R6 input word0");
        access(0, 4'd12, 2'd2, 4'h0, 32'h0, "R6 input word1");
        pad_in = 8'h3C;
        access(0, 4'd8, 2'd2, 4'h0, 32'h0, "R6 still old level");
        pin_exp = pad_in;
        access(0, 4'd8, 2'd2, 4'h0, 32'h0, "R6 new level");
        access(1, 4'd8, 2'd2, 4'hF, 32'h0, "R6 write input bank");
        access(0, 4'd0, 2'd2, 4'h0, 32'h0, "R6 outputs untouched");
        access(0, 4'd8, 2'd2, 4'h0, 32'h0, "R6 input untouched");

        // R7: push-pull
        cfg_out_en = '1;
        check_pads("R7 push-pull all");

        // R9: alternate function
        cfg_alt = 8'h01; alt_out = 8'h01; alt_oe = 8'h01;
        access(1, 4'd0, 2'd0, 4'hF, 32'h0, "R9 write while alt");
        check_pads("R9 pad follows alt");
        access(0, 4'd0, 2'd0, 4'h0, 32'h0, "R9 stored value");
        access(0, 4'd8, 2'd0, 4'h0, 32'h0, "R9 input visible");
        cfg_alt = '0;
        check_pads("R9 stored value applied");

        // R8: open drain
        cfg_od = 8'h02;
        check_pads("R8 od release");
        access(1, 4'd1, 2'd0, 4'hF, 32'h0, "R8 od write 0");
        check_pads("R8 od drive low");

        // R10: driver off
        cfg_out_en = '0;
        check_pads("R10 driver off");

        for (int i = 0; i < 400; i++) begin
            if (i % 16 == 0) begin
                cfg_alt = NP'($urandom); cfg_od = NP'($urandom);
                cfg_out_en = NP'($urandom); alt_out = NP'($urandom);
                alt_oe = NP'($urandom); pad_in = NP'($urandom);
                repeat (3) @(negedge clk);
                pin_exp = pad_in;
                check_pads("R7 random cfg pads");
            end
            access(1'($urandom), 4'($urandom), 2'($urandom), 4'($urandom),
                   $urandom, "R3 random");
            check_pads("R8 random pads");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule